// File: doc/BRIEF.md
# Critical interrupt context save unit

This unit holds the two save/restore registers that a small processor uses for critical interrupts: a return-address register and a state-save register. It also owns the live machine state register (MSR). When the core takes a critical interrupt, the unit records where to resume and a copy of the MSR as it was before the interrupt. It then clears the live MSR, except for a parameter-selected set of bits.

When the core executes a return-from-critical-interrupt, the unit raises a fetch redirect in the same cycle, carrying the saved address. On the next edge it reloads the MSR from the state-save register. Software can reach both save registers through a move-to/move-from special-purpose-register port, and can load the live MSR directly. Reserved bits are forced to zero on every write path. Same-cycle collisions between interrupt, return and software writes are settled by a fixed priority.

Top module: `crit_ctx_save`

## Requirements
- R1: When `crit_take_i` is high and `crit_ret_i` is low, the return-address register takes `crit_addr_i` with bits 1:0 cleared on the next edge.
- R2: When `crit_take_i` is high, the state-save register takes the MSR value from before that edge, with reserved bits (mask `MSR_RSVD_MASK`, default 32'hFFF8_000F, LSB-0 numbering) cleared.
- R3: When `crit_take_i` is high, the MSR becomes its previous value ANDed with `MSR_KEEP_MASK` (default 32'h0000_1000, which keeps bit 12).
- R4: When `crit_ret_i` is high and `crit_take_i` is low, `fetch_redirect_o` is high in that same cycle and `fetch_addr_o` equals the return-address register. Otherwise `fetch_redirect_o` is low.
- R5: When `crit_ret_i` is high and `crit_take_i` is low, the MSR takes the state-save register value on the next edge.
- R6: Bits 1:0 of the return-address register always read as zero.
- R7: Bits set in `MSR_RSVD_MASK` always read as zero in the state-save register and in the MSR, whatever the write source.
- R8: A software write (`spr_we_i`) updates the register chosen by `spr_wsel_i` on the next edge. Select 0 is the return-address register and select 1 is the state-save register. The written value is masked as in R6/R7.
- R9: A software write in a cycle with `crit_take_i` high is discarded for both registers, and the interrupt capture is kept.
- R10: When `crit_take_i` and `crit_ret_i` are both high, no redirect is issued and the return-address register keeps the pending return target as the resume address. R2 and R3 still apply.
- R11: `spr_rdata_o` shows the return-address register when `spr_rsel_i` is 0 and the state-save register when it is 1, with no delay.
- R12: While `rst_ni` is low, both save registers and the MSR are zero.
- R13: `msr_we_i` loads `msr_wdata_i`, masked as in R7, into the MSR on the next edge, but only when neither `crit_take_i` nor `crit_ret_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_take_i | input | 1 | Critical interrupt taken this cycle |
| crit_addr_i | input | 32 | Resume address offered by the interrupted process |
| crit_ret_i | input | 1 | Return-from-critical-interrupt executed this cycle |
| spr_we_i | input | 1 | Software write strobe for a save register |
| spr_wsel_i | input | 1 | Write target: 0 return address, 1 state save |
| spr_wdata_i | input | 32 | Software write data |
| spr_rsel_i | input | 1 | Read target: 0 return address, 1 state save |
| spr_rdata_o | output | 32 | Selected save register contents |
| msr_we_i | input | 1 | Software write strobe for the live MSR |
| msr_wdata_i | input | 32 | Live MSR write data |
| msr_o | output | 32 | Live machine state register |
| fetch_redirect_o | output | 1 | Fetch redirect request from a return |
| fetch_addr_o | output | 32 | Redirect target address |

## Verification
The bound checker watches every cycle for the following:
- Capture values for both registers after an interrupt, and the cleared MSR.
- The restore after a lone return, and the same-cycle redirect.
- Zeroed reserved and alignment bits.
- The outcome of interrupt-versus-write and interrupt-versus-return collisions.

The bench's reference model can show things the per-cycle properties cannot:
- That a chain of events leaves the right history, such as a restore that picks up a value software wrote several cycles earlier.
- A return in the cycle right after a capture.
- That an ignored MSR write left no trace in later reads.

// File: rtl/crit_ctx_pkg.sv
package crit_ctx_pkg;

  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_STATE = 1'b1
  } spr_sel_e;

  typedef struct packed {
    logic cap;
    logic sw;
  } ld_t;

endpackage

// File: rtl/crit_ctx_arb.sv
module crit_ctx_arb
  import crit_ctx_pkg::*;
(
  input  logic crit_take_i,
  input  logic crit_ret_i,
  input  logic spr_we_i,
  input  logic spr_wsel_i,
  input  logic msr_we_i,
  output ld_t  addr_ld_o,
  output ld_t  state_ld_o,
  output logic msr_clr_o,
  output logic msr_rest_o,
  output logic msr_sw_o,
  output logic redirect_o
);

  logic sel_state;
  assign sel_state = (spr_wsel_i == SEL_STATE);

  // priority: interrupt > return > software
  always_comb begin
    addr_ld_o.cap  = crit_take_i & ~crit_ret_i;
    addr_ld_o.sw   = spr_we_i & ~sel_state & ~crit_take_i;
    state_ld_o.cap = crit_take_i;
    state_ld_o.sw  = spr_we_i & sel_state & ~crit_take_i;
    msr_clr_o      = crit_take_i;
    msr_rest_o     = crit_ret_i & ~crit_take_i;
    msr_sw_o       = msr_we_i & ~crit_take_i & ~crit_ret_i;
    redirect_o     = crit_ret_i & ~crit_take_i;
  end

endmodule

// File: rtl/crit_ctx_sreg.sv
module crit_ctx_sreg
  import crit_ctx_pkg::*;
#(
  parameter int unsigned     W         = 32,
  parameter logic [W-1:0]    LIVE_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ld_t          ld_i,
  input  logic [W-1:0] cap_d_i,
  input  logic [W-1:0] sw_d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_q <= '0;
    else if (ld_i.cap)  q_q <= cap_d_i & LIVE_MASK;
    else if (ld_i.sw)   q_q <= sw_d_i & LIVE_MASK;
  end

  assign q_o = q_q;

endmodule

// File: rtl/crit_ctx_msr.sv
module crit_ctx_msr #(
  parameter int unsigned  W         = 32,
  parameter logic [W-1:0] RSVD_MASK = '0,
  parameter logic [W-1:0] KEEP_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rest_i,
  input  logic         sw_i,
  input  logic [W-1:0] rest_d_i,
  input  logic [W-1:0] sw_d_i,
  output logic [W-1:0] msr_o
);

  localparam logic [W-1:0] LIVE = ~RSVD_MASK;

  logic [W-1:0] msr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      msr_q <= '0;
    else if (clr_i)   msr_q <= msr_q & KEEP_MASK & LIVE;
    else if (rest_i)  msr_q <= rest_d_i & LIVE;
    else if (sw_i)    msr_q <= sw_d_i & LIVE;
  end

  assign msr_o = msr_q;

endmodule

// File: rtl/crit_ctx_save.sv
module crit_ctx_save
  import crit_ctx_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     ALIGN_BITS    = 2,
  parameter logic [XLEN-1:0] MSR_RSVD_MASK = 32'hFFF8_000F,
  parameter logic [XLEN-1:0] MSR_KEEP_MASK = 32'h0000_1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            crit_take_i,
  input  logic [XLEN-1:0] crit_addr_i,
  input  logic            crit_ret_i,
  input  logic            spr_we_i,
  input  logic            spr_wsel_i,
  input  logic [XLEN-1:0] spr_wdata_i,
  input  logic            spr_rsel_i,
  output logic [XLEN-1:0] spr_rdata_o,
  input  logic            msr_we_i,
  input  logic [XLEN-1:0] msr_wdata_i,
  output logic [XLEN-1:0] msr_o,
  output logic            fetch_redirect_o,
  output logic [XLEN-1:0] fetch_addr_o
);

  localparam logic [XLEN-1:0] ADDR_MASK  = {{(XLEN-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
  localparam logic [XLEN-1:0] STATE_MASK = ~MSR_RSVD_MASK;

  ld_t             addr_ld, state_ld;
  logic            msr_clr, msr_rest, msr_sw, redirect;
  logic [XLEN-1:0] sr0_q, sr1_q, msr_q;

  crit_ctx_arb u_arb (
    .crit_take_i (crit_take_i),
    .crit_ret_i  (crit_ret_i),
    .spr_we_i    (spr_we_i),
    .spr_wsel_i  (spr_wsel_i),
    .msr_we_i    (msr_we_i),
    .addr_ld_o   (addr_ld),
    .state_ld_o  (state_ld),
    .msr_clr_o   (msr_clr),
    .msr_rest_o  (msr_rest),
    .msr_sw_o    (msr_sw),
    .redirect_o  (redirect)
  );

  crit_ctx_sreg #(.W(XLEN), .LIVE_MASK(ADDR_MASK)) u_sr0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (addr_ld),
    .cap_d_i (crit_addr_i),
    .sw_d_i  (spr_wdata_i),
    .q_o     (sr0_q)
  );

  // capture sees msr_q before the clear lands on the same edge
  crit_ctx_sreg #(.W(XLEN), .LIVE_MASK(STATE_MASK)) u_sr1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (state_ld),
    .cap_d_i (msr_q),
    .sw_d_i  (spr_wdata_i),
    .q_o     (sr1_q)
  );

  crit_ctx_msr #(
    .W(XLEN), .RSVD_MASK(MSR_RSVD_MASK), .KEEP_MASK(MSR_KEEP_MASK)
  ) u_msr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (msr_clr),
    .rest_i   (msr_rest),
    .sw_i     (msr_sw),
    .rest_d_i (sr1_q),
    .sw_d_i   (msr_wdata_i),
    .msr_o    (msr_q)
  );

  assign spr_rdata_o      = (spr_rsel_i == SEL_STATE) ? sr1_q : sr0_q;
  assign msr_o            = msr_q;
  assign fetch_redirect_o = redirect;
  assign fetch_addr_o     = sr0_q;

endmodule

// File: rtl/crit_ctx_save_chk.sv
module crit_ctx_save_chk #(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     ALIGN_BITS    = 2,
  parameter logic [XLEN-1:0] MSR_RSVD_MASK = 32'hFFF8_000F,
  parameter logic [XLEN-1:0] MSR_KEEP_MASK = 32'h0000_1000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            crit_take_i,
  input logic [XLEN-1:0] crit_addr_i,
  input logic            crit_ret_i,
  input logic            spr_we_i,
  input logic            spr_wsel_i,
  input logic [XLEN-1:0] spr_wdata_i,
  input logic            spr_rsel_i,
  input logic [XLEN-1:0] spr_rdata_o,
  input logic            msr_we_i,
  input logic [XLEN-1:0] msr_wdata_i,
  input logic [XLEN-1:0] msr_o,
  input logic            fetch_redirect_o,
  input logic [XLEN-1:0] fetch_addr_o,
  input logic [XLEN-1:0] sr0_q,
  input logic [XLEN-1:0] sr1_q
);

  localparam logic [XLEN-1:0] AMASK = {{(XLEN-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  // R1
  addr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_take_i && !crit_ret_i |=> sr0_q == ($past(crit_addr_i) & AMASK));

  // R2
  state_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_take_i |=> sr1_q == ($past(msr_o) & ~MSR_RSVD_MASK));

  // R3
  msr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_take_i |=> msr_o == ($past(msr_o) & MSR_KEEP_MASK));

  // R4
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_ret_i && !crit_take_i |-> fetch_redirect_o && fetch_addr_o == sr0_q);

  // R4
  no_spurious_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crit_ret_i |-> !fetch_redirect_o);

  // R5
  msr_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_ret_i && !crit_take_i |=> msr_o == $past(sr1_q));

  // R6
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr0_q & ~AMASK) == '0);

  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sr1_q | msr_o) & MSR_RSVD_MASK) == '0);

  // R8
  spr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_we_i && !crit_take_i |=>
      ($past(spr_wsel_i) ? sr1_q == ($past(spr_wdata_i) & ~MSR_RSVD_MASK)
                         : sr0_q == ($past(spr_wdata_i) & AMASK)));

  // R9
  take_beats_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_take_i && spr_we_i && spr_wsel_i |=> sr1_q == ($past(msr_o) & ~MSR_RSVD_MASK));

  // R10
  take_ret_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_take_i && crit_ret_i |=> $stable(sr0_q));

  // R11
  spr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_rdata_o == (spr_rsel_i ? sr1_q : sr0_q));

  // R13
  msr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_we_i && !crit_take_i && !crit_ret_i |=> msr_o == ($past(msr_wdata_i) & ~MSR_RSVD_MASK));

  // R12
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (sr0_q == '0 && sr1_q == '0 && msr_o == '0);
    end
  end

endmodule

bind crit_ctx_save crit_ctx_save_chk #(
  .XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS),
  .MSR_RSVD_MASK(MSR_RSVD_MASK), .MSR_KEEP_MASK(MSR_KEEP_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .crit_take_i(crit_take_i), .crit_addr_i(crit_addr_i),
  .crit_ret_i(crit_ret_i), .spr_we_i(spr_we_i), .spr_wsel_i(spr_wsel_i),
  .spr_wdata_i(spr_wdata_i), .spr_rsel_i(spr_rsel_i), .spr_rdata_o(spr_rdata_o),
  .msr_we_i(msr_we_i), .msr_wdata_i(msr_wdata_i), .msr_o(msr_o),
  .fetch_redirect_o(fetch_redirect_o), .fetch_addr_o(fetch_addr_o),
  .sr0_q(sr0_q), .sr1_q(sr1_q)
);

// File: tb/crit_ctx_save_bench.sv
`timescale 1ns/1ps
module crit_ctx_save_bench;

  localparam logic [31:0] AMASK = 32'hFFFF_FFFC;
  localparam logic [31:0] RSVD  = 32'hFFF8_000F;
  localparam logic [31:0] KEEP  = 32'h0000_1000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic crit_take_i = 1'b0, crit_ret_i = 1'b0;
  logic [31:0] crit_addr_i = '0;
  logic spr_we_i = 1'b0, spr_wsel_i = 1'b0, spr_rsel_i = 1'b0;
  logic [31:0] spr_wdata_i = '0;
  logic msr_we_i = 1'b0;
  logic [31:0] msr_wdata_i = '0;
  logic [31:0] spr_rdata_o, msr_o, fetch_addr_o;
  logic fetch_redirect_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  crit_ctx_save u_crit_ctx_save (
    .clk_i(clk_i), .rst_ni(rst_ni), .crit_take_i(crit_take_i), .crit_addr_i(crit_addr_i),
    .crit_ret_i(crit_ret_i), .spr_we_i(spr_we_i), .spr_wsel_i(spr_wsel_i),
    .spr_wdata_i(spr_wdata_i), .spr_rsel_i(spr_rsel_i), .spr_rdata_o(spr_rdata_o),
    .msr_we_i(msr_we_i), .msr_wdata_i(msr_wdata_i), .msr_o(msr_o),
    .fetch_redirect_o(fetch_redirect_o), .fetch_addr_o(fetch_addr_o)
  );

  // reference model
  logic [31:0] m_ra = '0, m_ss = '0, m_msr = '0;
  bit p_take = 0, p_ret = 0, p_swe = 0, p_msrwe = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ra = '0; m_ss = '0; m_msr = '0;
    end else if (crit_take_i) begin
      m_ss = m_msr & ~RSVD;
      if (!crit_ret_i) m_ra = crit_addr_i & AMASK;
      m_msr = m_msr & KEEP;
    end else begin
      if (crit_ret_i) m_msr = m_ss & ~RSVD;
      else if (msr_we_i) m_msr = msr_wdata_i & ~RSVD;
      if (spr_we_i) begin
        if (spr_wsel_i) m_ss = spr_wdata_i & ~RSVD;
        else            m_ra = spr_wdata_i & AMASK;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a falling edge; checks combinational outputs, then one cycle passes
  task automatic cyc(input bit take, input logic [31:0] a, input bit ret,
                     input bit swe, input bit wsel, input logic [31:0] wd,
                     input bit rsel, input bit mwe, input logic [31:0] mw);
    string t_msr, t_rd, t_fe;
    logic [31:0] exp_rd;
    crit_take_i = take; crit_addr_i = a; crit_ret_i = ret;
    spr_we_i = swe; spr_wsel_i = wsel; spr_wdata_i = wd;
    spr_rsel_i = rsel; msr_we_i = mwe; msr_wdata_i = mw;
    #1;
    t_msr = p_take ? "R3" : p_ret ? "R5" : p_msrwe ? "R13" : "R7";
    t_rd  = (p_take && p_swe) ? "R9" : p_take ? (rsel ? "R2" : "R1") : p_swe ? "R8" : "R11";
    t_fe  = (take && ret) ? "R10" : "R4";
    exp_rd = rsel ? m_ss : m_ra;
    chk(msr_o === m_msr, t_msr, msr_o, m_msr);
    chk(spr_rdata_o === exp_rd, t_rd, spr_rdata_o, exp_rd);
    chk(fetch_redirect_o === (ret && !take), t_fe, {31'd0, fetch_redirect_o}, {31'd0, ret && !take});
    if (ret && !take) chk(fetch_addr_o === m_ra, "R4", fetch_addr_o, m_ra);
    p_take = take; p_ret = ret; p_swe = swe; p_msrwe = mwe;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(input bit rsel);
    cyc(0, '0, 0, 0, 0, '0, rsel, 0, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk_i);
    spr_rsel_i = 0; #1;
    chk(spr_rdata_o === '0 && msr_o === '0, "R12", spr_rdata_o | msr_o, 32'd0);
    spr_rsel_i = 1; #1;
    chk(spr_rdata_o === '0, "R12", spr_rdata_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R13 / R7 msr writes with reserved bits set
    cyc(0, '0, 0, 0, 0, '0, 0, 1, 32'hFFFF_FFFF);
    idle(0);
    chk(msr_o === 32'h0007_FFF0, "R7", msr_o, 32'h0007_FFF0);
    // R8 / R6 software writes to both registers
    cyc(0, '0, 0, 1, 0, 32'h1234_5677, 0, 0, '0);
    idle(0);
    chk(spr_rdata_o[1:0] === 2'b00, "R6", {30'd0, spr_rdata_o[1:0]}, 32'd0);
    cyc(0, '0, 0, 1, 1, 32'hFFFF_0F0F, 1, 0, '0);
    idle(1);
    chk(spr_rdata_o === 32'h0007_0F00, "R7", spr_rdata_o, 32'h0007_0F00);
    // R1/R2/R3 interrupt capture
    cyc(1, 32'h0000_4003, 0, 0, 0, '0, 1, 0, '0);
    idle(1); idle(0);
    // R4/R5 return restores
    cyc(0, '0, 1, 0, 0, '0, 0, 0, '0);
    idle(0);
    chk(msr_o === 32'h0007_FFF0, "R5", msr_o, 32'h0007_FFF0);
    // R9 interrupt beats software write to each register
    cyc(1, 32'h0000_8000, 0, 1, 1, 32'h0000_0AA0, 1, 0, '0);
    idle(1);
    cyc(1, 32'h0000_9000, 0, 1, 0, 32'h0000_0550, 0, 0, '0);
    idle(0);
    // R10 interrupt and return collide
    cyc(0, '0, 0, 0, 0, '0, 0, 1, 32'h0000_3330);
    cyc(1, 32'hDEAD_BEE0, 1, 0, 0, '0, 0, 0, '0);
    idle(0);
    chk(spr_rdata_o === 32'h0000_9000, "R10", spr_rdata_o, 32'h0000_9000);
    // R13 write ignored during return and during interrupt
    cyc(0, '0, 1, 0, 0, '0, 1, 1, 32'h0000_FFF0);
    idle(1);
    cyc(1, 32'h10, 0, 0, 0, '0, 1, 1, 32'h0000_FFF0);
    idle(1);
    // return right after a capture, and return with same-cycle write to state reg
    cyc(0, '0, 0, 0, 0, '0, 0, 1, 32'h0001_2340);
    cyc(1, 32'h0000_2224, 0, 0, 0, '0, 1, 0, '0);
    cyc(0, '0, 1, 1, 1, 32'h0000_5550, 1, 0, '0);
    idle(1);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      automatic int r = $urandom_range(0, 99);
      cyc(r < 15, $urandom, (r >= 10 && r < 30), ($urandom_range(0, 3) == 0), $urandom_range(0, 1),
          $urandom, $urandom_range(0, 1), ($urandom_range(0, 3) == 0), $urandom);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule